// File: doc/BRIEF.md
# DRAM Direct Command Register

This block is a single 32-bit write register through which software places one raw command on a DRAM command bus. This is used during memory bring-up, for example to send mode-register writes, precharge-all, refresh and ZQ calibration. A write carries a launch flag, a rank mask, a bank address, a command-address value and an opcode. If the block is idle and the launch flag is set, it captures the word and decodes the opcode into chip-select, RAS_n, CAS_n and WE_n levels. It drives that command for one clock and then holds itself busy for a per-opcode number of cycles. When that time has passed, it clears the launch flag in the readback. Software polls the flag to learn that the command has finished.

The register interface is a plain write strobe with a data word and a continuous readback. The register has no back-pressure. A write made while a command is in flight is dropped, and software is expected to poll before the next write. Bits 30:22 are spare bits: they are stored and read back but have no effect on the command.

Top module: `dram_cmd_issue`

## Requirements
- R1: A write with bit 31 set, made while idle, launches the command. Readback bit 31 is 1 from the next cycle until the hold time ends and is 0 after that. Readback bits 30:0 return the accepted word.
- R2: Rank select is bits 21:20. When the command is driven, cmd_cs_n[i] is low exactly when rank bit i is 1, so a value of 3 selects both ranks at once.
- R3: Bank is bits 19:17 and command address is bits 16:4. Both appear on cmd_ba and cmd_addr for the mode-register set and mode-register read opcodes.
- R4: Opcode is bits 3:0. The RAS_n/CAS_n/WE_n levels are:
  - 1 precharge-all: 0/1/0
  - 2 refresh: 0/0/1
  - 3 mode-register set: 0/0/0
  - 4 ZQ short calibration: 1/1/0
  - 5 ZQ long calibration: 1/1/0
  - 8 mode-register read: 1/0/1
- R5: Precharge-all and ZQ long calibration drive cmd_addr = 0x400, which sets A10. ZQ short calibration and refresh drive cmd_addr = 0 and cmd_ba = 0, and the address field in the written word is ignored for them.
- R6: The decoded command is on the bus for exactly the first busy cycle. On every other cycle the bus is deselect: cmd_cs_n = 2'b11, RAS_n/CAS_n/WE_n high, and bank and address zero.
- R7: The number of cycles the flag reads 1 depends on the opcode. With the default parameters these counts are:
  - deselect 1
  - precharge-all 4
  - refresh 8
  - mode-register set 4
  - ZQ short 6
  - ZQ long 16, the longest
  - reset-low 3
  - mode-register read 5
- R8: A write made while busy is ignored. The readback and the bus continue the command in flight, and its total hold time is unchanged.
- R9: Opcodes 7 and 9 to 15 are stored but never set the busy flag, so bit 31 reads 0 on the next cycle and the bus stays deselect. A write with bit 31 clear changes nothing.
- R10: Opcode 0 (deselect) keeps cmd_cs_n = 2'b11 while it is busy.
- R11: Opcode 6 (reset-low) drives mem_reset_n low for its whole busy period with both chip-selects high. Otherwise mem_reset_n is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write word |
| rd_data | output | 32 | Readback: bit 31 busy flag, bits 30:0 accepted word |
| cmd_cs_n | output | 2 | Per-rank chip-select, active low |
| cmd_ras_n | output | 1 | Row strobe level |
| cmd_cas_n | output | 1 | Column strobe level |
| cmd_we_n | output | 1 | Write-enable level |
| cmd_ba | output | 3 | Bank address |
| cmd_addr | output | 13 | Command address |
| mem_reset_n | output | 1 | DRAM reset, active low |

## Verification
The assertions assume that every hold parameter is at least 1. They also assume that wr_en and wr_data change only away from the clock edge. The bench drives its writes at the falling edge and reads the bus and readback at the following falling edges. In every case a single write is followed by polling to completion, except for one deliberate write into a busy command, which checks that a dropped write disturbs nothing.

// File: rtl/dci_pkg.sv
package dci_pkg;
  typedef enum logic [3:0] {
    OP_DESEL = 4'd0,
    OP_PREA  = 4'd1,
    OP_REF   = 4'd2,
    OP_MRS   = 4'd3,
    OP_ZQCS  = 4'd4,
    OP_ZQCL  = 4'd5,
    OP_RSTL  = 4'd6,
    OP_MRR   = 4'd8
  } dci_op_e;

  localparam int unsigned WORD_W = 32;
  localparam int unsigned START_BIT = 31;
  localparam int unsigned RANK_LO = 20;
  localparam int unsigned BANK_LO = 17;
  localparam int unsigned ADDR_LO = 4;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/dci_hold.sv
module dci_hold
  import dci_pkg::*;
#(
  parameter int unsigned H_DESEL = 1,
  parameter int unsigned H_PREA  = 4,
  parameter int unsigned H_REF   = 8,
  parameter int unsigned H_MRS   = 4,
  parameter int unsigned H_ZQCS  = 6,
  parameter int unsigned H_ZQCL  = 16,
  parameter int unsigned H_RSTL  = 3,
  parameter int unsigned H_MRR   = 5,
  parameter int unsigned CW      = 5
) (
  input  logic [3:0]    op,
  output logic          known,
  output logic [CW-1:0] hold
);
  always_comb begin
    known = 1'b1;
    hold  = '0;
    case (op)
      OP_DESEL: hold = CW'(H_DESEL);
      OP_PREA:  hold = CW'(H_PREA);
      OP_REF:   hold = CW'(H_REF);
      OP_MRS:   hold = CW'(H_MRS);
      OP_ZQCS:  hold = CW'(H_ZQCS);
      OP_ZQCL:  hold = CW'(H_ZQCL);
      OP_RSTL:  hold = CW'(H_RSTL);
      OP_MRR:   hold = CW'(H_MRR);
      default:  known = 1'b0;
    endcase
  end
endmodule

// File: rtl/dci_timer.sv
module dci_timer #(
  parameter int unsigned CW = 5,
  parameter int unsigned MAXH = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          busy
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt_q <= '0;
    end else if (load) begin
      busy  <= 1'b1;
      cnt_q <= load_val - CW'(1);
    end else if (busy) begin
      if (cnt_q == '0) busy <= 1'b0;
      else cnt_q <= cnt_q - CW'(1);
    end
  end

  AST_LOAD_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> busy); // R1
  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt_q < CW'(MAXH))); // R7
endmodule

// File: rtl/dci_cmdgen.sv
module dci_cmdgen
  import dci_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        issue,
  input  logic        busy,
  input  logic [3:0]  op,
  input  logic [1:0]  rank,
  input  logic [2:0]  ba,
  input  logic [12:0] addr,
  output logic [1:0]  cs_n,
  output logic        ras_n,
  output logic        cas_n,
  output logic        we_n,
  output logic [2:0]  ba_o,
  output logic [12:0] addr_o,
  output logic        reset_n
);
  localparam logic [12:0] A10 = 13'h0400;
  logic sel;
  logic [2:0] rcw;

  always_comb begin
    sel    = 1'b1;
    rcw    = 3'b111;
    ba_o   = '0;
    addr_o = '0;
    case (op)
      OP_PREA: begin rcw = 3'b010; addr_o = A10; end
      OP_REF:  rcw = 3'b001;
      OP_MRS:  begin rcw = 3'b000; ba_o = ba; addr_o = addr; end
      OP_ZQCS: rcw = 3'b110;
      OP_ZQCL: begin rcw = 3'b110; addr_o = A10; end
      OP_MRR:  begin rcw = 3'b101; ba_o = ba; addr_o = addr; end
      default: sel = 1'b0;
    endcase
    if (!(issue && sel)) begin
      rcw    = 3'b111;
      ba_o   = '0;
      addr_o = '0;
    end
    cs_n = (issue && sel) ? ~rank : 2'b11;
    {ras_n, cas_n, we_n} = rcw;
    reset_n = !(busy && op == OP_RSTL);
  end

  AST_RSTL_NO_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    !reset_n |-> (cs_n == 2'b11)); // R11
endmodule

// File: rtl/dram_cmd_issue.sv
module dram_cmd_issue
  import dci_pkg::*;
#(
  parameter int unsigned H_DESEL = 1,
  parameter int unsigned H_PREA  = 4,
  parameter int unsigned H_REF   = 8,
  parameter int unsigned H_MRS   = 4,
  parameter int unsigned H_ZQCS  = 6,
  parameter int unsigned H_ZQCL  = 16,
  parameter int unsigned H_RSTL  = 3,
  parameter int unsigned H_MRR   = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  output logic [1:0]  cmd_cs_n,
  output logic        cmd_ras_n,
  output logic        cmd_cas_n,
  output logic        cmd_we_n,
  output logic [2:0]  cmd_ba,
  output logic [12:0] cmd_addr,
  output logic        mem_reset_n
);
  localparam int unsigned MAXH = max2(max2(max2(H_DESEL, H_PREA), max2(H_REF, H_MRS)),
                                      max2(max2(H_ZQCS, H_ZQCL), max2(H_RSTL, H_MRR)));
  localparam int unsigned CW = $clog2(MAXH + 1);

  logic [30:0]   word_q;
  logic          issue_q;
  logic          busy;
  logic          known;
  logic [CW-1:0] hold;
  logic          accept;

  assign accept = wr_en && wr_data[START_BIT] && !busy;

  dci_hold #(
    .H_DESEL(H_DESEL), .H_PREA(H_PREA), .H_REF(H_REF), .H_MRS(H_MRS),
    .H_ZQCS(H_ZQCS), .H_ZQCL(H_ZQCL), .H_RSTL(H_RSTL), .H_MRR(H_MRR), .CW(CW)
  ) u_hold (
    .op(wr_data[3:0]), .known(known), .hold(hold)
  );

  dci_timer #(.CW(CW), .MAXH(MAXH)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(accept && known), .load_val(hold), .busy(busy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q  <= '0;
      issue_q <= 1'b0;
    end else begin
      issue_q <= accept && known;
      if (accept) word_q <= wr_data[30:0];
    end
  end

  assign rd_data = {busy, word_q};

  dci_cmdgen u_cmdgen (
    .clk(clk), .rst_n(rst_n), .issue(issue_q), .busy(busy),
    .op(word_q[3:0]), .rank(word_q[RANK_LO+1:RANK_LO]),
    .ba(word_q[BANK_LO+2:BANK_LO]), .addr(word_q[ADDR_LO+12:ADDR_LO]),
    .cs_n(cmd_cs_n), .ras_n(cmd_ras_n), .cas_n(cmd_cas_n), .we_n(cmd_we_n),
    .ba_o(cmd_ba), .addr_o(cmd_addr), .reset_n(mem_reset_n)
  );

  AST_BUSY_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_en) |=> $stable(word_q)); // R8
  AST_ISSUE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    issue_q |=> !issue_q); // R6
  AST_IDLE_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (cmd_cs_n == 2'b11)); // R6
  AST_UNKNOWN_NO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !known) |=> !busy); // R9
endmodule

// File: tb/dram_cmd_issue_tb.sv
module dram_cmd_issue_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [1:0]  cmd_cs_n;
  logic        cmd_ras_n, cmd_cas_n, cmd_we_n;
  logic [2:0]  cmd_ba;
  logic [12:0] cmd_addr;
  logic        mem_reset_n;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  dram_cmd_issue u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .cmd_cs_n(cmd_cs_n), .cmd_ras_n(cmd_ras_n), .cmd_cas_n(cmd_cas_n),
    .cmd_we_n(cmd_we_n), .cmd_ba(cmd_ba), .cmd_addr(cmd_addr), .mem_reset_n(mem_reset_n)
  );

  typedef struct packed {
    logic [31:0] w;
    logic [1:0]  cs;
    logic [2:0]  rcw;
    logic [2:0]  ba;
    logic [12:0] ad;
    logic [7:0]  hold;
    logic        rstl;
    logic [7:0]  tag;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{32'h8030_0000, 2'b11, 3'b111, 3'd0, 13'h0000, 8'd1,  1'b0, 8'd10},
    '{32'h8030_0001, 2'b00, 3'b010, 3'd0, 13'h0400, 8'd4,  1'b0, 8'd5},
    '{32'h8010_0002, 2'b10, 3'b001, 3'd0, 13'h0000, 8'd8,  1'b0, 8'd4},
    '{32'h8034_4203, 2'b00, 3'b000, 3'd2, 13'h0420, 8'd4,  1'b0, 8'd3},
    '{32'h802F_FFF3, 2'b01, 3'b000, 3'd7, 13'h1FFF, 8'd4,  1'b0, 8'd2},
    '{32'h8031_2344, 2'b00, 3'b110, 3'd0, 13'h0000, 8'd6,  1'b0, 8'd5},
    '{32'h8010_0005, 2'b10, 3'b110, 3'd0, 13'h0400, 8'd16, 1'b0, 8'd7},
    '{32'h8030_0006, 2'b11, 3'b111, 3'd0, 13'h0000, 8'd3,  1'b1, 8'd11},
    '{32'h8016_0048, 2'b10, 3'b101, 3'd3, 13'h0004, 8'd5,  1'b0, 8'd3},
    '{32'h8030_0007, 2'b11, 3'b111, 3'd0, 13'h0000, 8'd0,  1'b0, 8'd9},
    '{32'h8030_000F, 2'b11, 3'b111, 3'd0, 13'h0000, 8'd0,  1'b0, 8'd9}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic write_word(input logic [31:0] w);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = w;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic count_busy(output int n);
    n = 0;
    while (rd_data[31] && n < 100) begin
      if (n > 0) chk("R6 deselect after issue cycle", {30'd0, cmd_cs_n}, 32'h3);
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    #4_000_000;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk("R1 reset readback", rd_data, 32'h0);
    chk("R6 reset cs_n", {30'd0, cmd_cs_n}, 32'h3);
    chk("R11 reset mem_reset_n", {31'd0, mem_reset_n}, 32'h1);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      write_word(VEC[i].w);
      chk($sformatf("R2 cs_n vec%0d", i), {30'd0, cmd_cs_n}, {30'd0, VEC[i].cs});
      chk($sformatf("R4 ras/cas/we vec%0d", i), {29'd0, cmd_ras_n, cmd_cas_n, cmd_we_n},
          {29'd0, VEC[i].rcw});
      chk($sformatf("R3 bank vec%0d", i), {29'd0, cmd_ba}, {29'd0, VEC[i].ba});
      chk($sformatf("R5 addr vec%0d", i), {19'd0, cmd_addr}, {19'd0, VEC[i].ad});
      chk($sformatf("R11 mem_reset_n vec%0d", i), {31'd0, mem_reset_n}, {31'd0, ~VEC[i].rstl});
      chk($sformatf("R1 readback word vec%0d", i), {1'b0, rd_data[30:0]}, {1'b0, VEC[i].w[30:0]});
      count_busy(n);
      chk($sformatf("R7 hold cycles vec%0d (R%0d)", i, VEC[i].tag), n, {24'd0, VEC[i].hold});
      chk($sformatf("R1 flag clear vec%0d", i), {31'd0, rd_data[31]}, 32'h0);
    end

    // R10 deselect: both chip-selects stay high over the whole busy window
    write_word(32'h8030_0000);
    chk("R10 deselect cs_n", {30'd0, cmd_cs_n}, 32'h3);
    chk("R10 deselect busy", {31'd0, rd_data[31]}, 32'h1);
    @(negedge clk);
    chk("R10 deselect done", {31'd0, rd_data[31]}, 32'h0);

    // R8: write during ZQ long is dropped
    write_word(32'h8010_0005);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = 32'h8030_0003;
    @(negedge clk);
    wr_en = 1'b0;
    chk("R8 readback kept", rd_data, 32'h8010_0005);
    chk("R8 bus stays deselect", {30'd0, cmd_cs_n}, 32'h3);
    count_busy(n);
    chk("R8 total hold unchanged", n + 2, 32'd16);

    // R9: write with start clear while idle changes nothing
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = 32'h0030_0002;
    @(negedge clk);
    wr_en = 1'b0;
    chk("R9 start-clear not busy", rd_data, 32'h0010_0005);
    chk("R9 start-clear bus", {30'd0, cmd_cs_n}, 32'h3);
    @(negedge clk);
    chk("R9 still idle", {31'd0, rd_data[31]}, 32'h0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule